// File: doc/BRIEF.md
# Receive Character FIFO with Per-Entry Error Tags

This block holds received characters on their way from a serial receiver to software. Every stored entry keeps its data byte together with three error tags: parity, framing and break. The block also builds the receive part of an 8-bit line status byte. The tag bits in that byte always describe the character at the head, not the most recent error that arrived. A status read hides those tags, and the overrun flag, until the head changes. A data read pops the head.

A mode input picks between a 16-deep FIFO and a single holding register. The two modes handle overrun in opposite ways. The single register is overwritten by the new character. A full FIFO discards the new character and keeps what it already holds. Changing the mode empties both stores. The two transmit-side status bits are not generated here: they are passed through from inputs.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, status bits 7, 4, 3, 2, 1 and 0 are all 0.
- R2: In FIFO mode characters leave in arrival order, and `head_data` shows the oldest held character whenever status bit 0 is 1.
- R3: Status bits 4 (break), 3 (framing) and 2 (parity) show the tags stored with the head character. They are 0 when nothing is held. After a data read pops the head, they show the tags of the next character.
- R4: A status read forces bits 4, 3, 2 and 1 to 0 from the next cycle. Bits 4..2 stay hidden until the head character changes.
- R5: In single-register mode, a character that arrives while the register is occupied and not being read in that cycle overwrites it and sets status bit 1 (overrun).
- R6: In FIFO mode, a character that arrives while 16 entries are held is dropped, the stored entries are unchanged, and bit 1 is set. Fullness is judged before any data read in the same cycle.
- R7: Status bit 7 (FIFO error) is 0 in single-register mode. In FIFO mode it is 1 while any held entry carries a tag, unless hidden under R8.
- R8: A status read clears bit 7 only if the head is the sole tagged entry and it is not popped in that cycle. Bit 7 returns when another tagged character is accepted.
- R9: If a status read falls in the same cycle as an event that sets a bit (an overrun, or a new head character), the set wins.
- R10: Status bit 0 (data ready) is 1 while a character is held. In single-register mode a data read clears it unless a new character arrives in the same cycle. In FIFO mode it clears only when the last entry is popped.
- R11: A change of `fifo_en` empties the FIFO and the holding register. Any character arriving in that cycle is dropped.
- R12: Status bits 6 and 5 copy `tx_shift_empty` and `tx_hold_empty` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding register |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_data | input | 8 | Received byte |
| rx_pe | input | 1 | Parity error tag of the offered character |
| rx_fe | input | 1 | Framing error tag of the offered character |
| rx_bi | input | 1 | Break tag of the offered character |
| rd_data | input | 1 | Data-register read strobe (pops the head) |
| rd_status | input | 1 | Status-register read strobe |
| tx_shift_empty | input | 1 | Transmit shifter empty, passed to status bit 6 |
| tx_hold_empty | input | 1 | Transmit holding empty, passed to status bit 5 |
| head_data | output | 8 | Byte at the head of the store |
| status | output | 8 | {fifo_err, tx_shift_empty, tx_hold_empty, bi, fe, pe, oe, dr} |

## Verification
Two collisions carry most of the risk. The first is a status read together with an overrun. The second is a status read together with a change of head character, either a pop or a first write into an empty store. Directed steps provoke both: the FIFO is filled to 16, and a further character and a status read are offered in the same cycle. A tagged character is written into an empty store together with a status read. A behavioural queue model in the bench decides the outcome, and it is compared on every clock. The model requires that the overrun flag and the newly shown tags stay set.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_pe,
  input  logic          rx_fe,
  input  logic          rx_bi,
  input  logic          rd_data,
  input  logic          rd_status,
  input  logic          tx_shift_empty,
  input  logic          tx_hold_empty,
  output logic [DW-1:0] head_data,
  output logic [7:0]    status
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 3;
  localparam logic [AW:0] FULLN = (AW+1)'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp, ecnt;
  logic [EW-1:0] hold;
  logic          hold_v, en_q, oe_q, hide_q, rhide_q;

  wire [AW:0]   cnt      = wp - rp;
  wire          empty    = (cnt == '0);
  wire          full     = (cnt == FULLN);
  wire          flush    = (fifo_en != en_q);
  wire [EW-1:0] in_w     = {rx_bi, rx_fe, rx_pe, rx_data};
  wire          in_err   = rx_pe | rx_fe | rx_bi;
  wire [EW-1:0] head     = fifo_en ? mem[rp[AW-1:0]] : hold;
  wire          have     = fifo_en ? !empty : hold_v;
  wire          head_err = |head[EW-1:DW];

  wire push   = !flush && fifo_en && rx_valid && !full;
  wire pop    = !flush && fifo_en && rd_data && !empty;
  wire s_load = !flush && !fifo_en && rx_valid;
  wire s_take = !flush && !fifo_en && rd_data && hold_v;
  wire ovr    = !flush && rx_valid && (fifo_en ? full : (hold_v && !rd_data));
  wire new_hd = pop || (push && empty) || s_load;

  wire [AW:0] ecnt_nx = ecnt + (AW+1)'(push && in_err) - (AW+1)'(pop && head_err);

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= in_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; ecnt <= '0;
      hold <= '0; hold_v <= 1'b0; en_q <= 1'b0;
      oe_q <= 1'b0; hide_q <= 1'b0; rhide_q <= 1'b0;
    end else begin
      en_q <= fifo_en;
      if (flush) begin
        wp <= '0; rp <= '0; ecnt <= '0;
        hold_v <= 1'b0; rhide_q <= 1'b0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
        ecnt <= ecnt_nx;
        if (s_load) begin
          hold <= in_w; hold_v <= 1'b1;
        end else if (s_take) begin
          hold_v <= 1'b0;
        end
        if (push && in_err)
          rhide_q <= 1'b0;
        else if (rd_status && ecnt == (AW+1)'(1) && have && head_err && !pop)
          rhide_q <= 1'b1;
        else if (ecnt_nx == '0)
          rhide_q <= 1'b0;
      end
      if (ovr)            oe_q <= 1'b1;
      else if (rd_status) oe_q <= 1'b0;
      if (flush || new_hd) hide_q <= 1'b0;
      else if (rd_status)  hide_q <= 1'b1;
    end
  end

  wire show = have && !hide_q;
  wire rfe  = fifo_en && (ecnt != '0) && !rhide_q;

  assign head_data = head[DW-1:0];
  assign status = {rfe, tx_shift_empty, tx_hold_empty,
                   head[DW+2] & show, head[DW+1] & show, head[DW] & show,
                   oe_q, have};
endmodule

module rx_err_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       rx_valid,
  input logic       rd_data,
  input logic       rd_status,
  input logic [7:0] status
);
  p_tags_need_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> status[4:2] == 3'b000);

  p_single_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_valid && status[0] && !rd_data) |=> status[1]);

  p_status_clears_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !rx_valid) |=> !status[1]);

  p_status_hides_tags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rd_status && !rd_data && !rx_valid) |=> status[4:2] == 3'b000);

  p_single_read_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rd_data && !rx_valid) |=> !status[0]);

  p_rfe_fifo_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !status[7]);
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (.*);

// File: tb/rx_err_fifo_bench.sv
module rx_err_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b0, rx_valid = 1'b0, rx_pe = 1'b0, rx_fe = 1'b0, rx_bi = 1'b0;
  logic rd_data = 1'b0, rd_status = 1'b0, tx_shift_empty = 1'b0, tx_hold_empty = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] head_data, status;

  always #10 clk = ~clk;

  rx_err_fifo u_rx_err_fifo (.*);

  int vecs = 0, bad = 0, cycles = 0;
  bit done = 0;

  logic [10:0] q[$];
  logic [10:0] m_hold;
  bit m_hv, m_en, m_oe, m_hide, m_rhide;

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic int errs();
    int n = 0;
    foreach (q[i]) if (q[i][10:8] != 0) n++;
    return n;
  endfunction

  function automatic void m_reset();
    q.delete(); m_hold = '0; m_hv = 0; m_en = 0; m_oe = 0; m_hide = 0; m_rhide = 0;
  endfunction

  task automatic compare();
    bit have = fifo_en ? (q.size() != 0) : m_hv;
    logic [10:0] hd = fifo_en ? (q.size() != 0 ? q[0] : 11'h0) : m_hold;
    bit show = have && !m_hide;
    bit rfe = fifo_en && errs() > 0 && !m_rhide;
    chk("R10 dr", status[0], have);
    chk("R6 oe", status[1], m_oe);
    chk("R3 tags", status[4:2], show ? hd[10:8] : 0);
    chk("R7 rfe", status[7], rfe);
    chk("R12 tx bits", status[6:5], {tx_shift_empty, tx_hold_empty});
    if (have) chk("R2 head", head_data, hd[7:0]);
  endtask

  function automatic void m_step();
    bit flush = (fifo_en != m_en);
    bit empty = (q.size() == 0), full = (q.size() == 16);
    bit have = fifo_en ? !empty : m_hv;
    logic [10:0] hd = fifo_en ? (empty ? 11'h0 : q[0]) : m_hold;
    bit in_err = rx_pe | rx_fe | rx_bi;
    bit push = !flush && fifo_en && rx_valid && !full;
    bit pop = !flush && fifo_en && rd_data && !empty;
    bit ovr = !flush && rx_valid && (fifo_en ? full : (m_hv && !rd_data));
    bit newh = pop || (push && empty) || (!flush && !fifo_en && rx_valid);
    int e0 = errs();
    m_en = fifo_en;
    if (flush) begin
      q.delete(); m_hv = 0; m_rhide = 0;
    end else begin
      if (push && in_err) m_rhide = 0;
      else if (rd_status && e0 == 1 && have && hd[10:8] != 0 && !pop) m_rhide = 1;
      if (pop) void'(q.pop_front());
      if (push) q.push_back({rx_bi, rx_fe, rx_pe, rx_data});
      if (!fifo_en) begin
        if (rx_valid) begin m_hold = {rx_bi, rx_fe, rx_pe, rx_data}; m_hv = 1; end
        else if (rd_data) m_hv = 0;
      end
      if (errs() == 0 && !(push && in_err)) m_rhide = 0;
    end
    if (ovr) m_oe = 1; else if (rd_status) m_oe = 0;
    if (flush || newh) m_hide = 0; else if (rd_status) m_hide = 1;
  endfunction

  task automatic cyc(bit v, logic [7:0] d, logic [2:0] tag, bit rd, bit rs);
    rx_valid = v; rx_data = d; {rx_bi, rx_fe, rx_pe} = tag;
    rd_data = rd; rd_status = rs;
    m_step();
    @(posedge clk); @(negedge clk);
    cycles++;
    compare();
    rx_valid = 0; rd_data = 0; rd_status = 0;
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {status[7], status[4:0]}, 0);
    compare();

    // single-register mode
    cyc(1, 8'h41, 3'b000, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R10 single read clears dr", status[0], 0);
    cyc(1, 8'h42, 3'b000, 0, 0);
    cyc(1, 8'h43, 3'b000, 0, 0);
    chk("R5 overwrite oe", status[1], 1);
    chk("R5 overwrite data", head_data, 8'h43);
    cyc(1, 8'h44, 3'b001, 0, 1);
    chk("R9 oe set wins over status read", status[1], 1);
    chk("R9 new head tags shown", status[2], 1);
    cyc(0, 0, 0, 0, 1);
    chk("R4 status read hides pe and oe", status[2:1], 0);
    cyc(1, 8'h45, 3'b100, 1, 0);
    chk("R10 read with new char keeps dr", status[0], 1);
    chk("R5 no overrun when read in same cycle", status[1], 0);

    // FIFO mode
    fifo_en = 1;
    cyc(0, 0, 0, 0, 0);
    chk("R11 flush on mode change", status[0], 0);
    cyc(1, 8'h10, 3'b000, 0, 0);
    cyc(1, 8'h11, 3'b010, 0, 0);
    cyc(1, 8'h12, 3'b100, 0, 0);
    chk("R3 clean head hides later tags", status[4:2], 0);
    chk("R7 rfe with tagged entries", status[7], 1);
    cyc(0, 0, 0, 1, 0);
    chk("R3 framing tag at head", status[4:2], 3'b010);
    cyc(0, 0, 0, 0, 1);
    chk("R8 rfe stays with later error", status[7], 1);
    cyc(0, 0, 0, 1, 0);
    chk("R3 break tag after pop", status[4:2], 3'b100);
    cyc(0, 0, 0, 0, 1);
    chk("R8 rfe cleared when head is sole error", status[7], 0);
    cyc(1, 8'h13, 3'b001, 0, 0);
    chk("R8 rfe returns on new error", status[7], 1);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R10 fifo empty clears dr", status[0], 0);
    for (int i = 0; i < 16; i++) cyc(1, 8'h80 + 8'(i), 3'b000, 0, 0);
    cyc(1, 8'hEE, 3'b000, 1, 1);
    chk("R6 full drop sets oe", status[1], 1);
    chk("R6 head kept", head_data, 8'h81);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 299) == 0) fifo_en = ~fifo_en;
      tx_shift_empty = 1'($urandom); tx_hold_empty = 1'($urandom);
      cyc(1'($urandom_range(0, 1)), 8'($urandom),
          {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)},
          ($urandom_range(0, 9) < (i % 500 < 250 ? 2 : 6)), ($urandom_range(0, 4) == 0));
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule